// File: doc/BRIEF.md
# Sliced-return parallel link master

This block is the host end of a byte-wide parallel link. Outbound data goes as a full byte on eight data lines with one handshake strobe. Inbound data comes back on only three return lines plus a handshake line. The peer therefore returns each byte in four three-bit slices. The master toggles its strobe between slices and waits for the peer's handshake line to reach alternating levels. The fourth slice carries a firmware version flag. After it, the master waits until the link is fully quiet before it treats the byte as complete.

A stream front end takes one request at a time. The request says send or receive and how many bytes (one to four). The front end splits or assembles the value most significant byte first. It returns a single response that carries the received word, the version flag, a framing error flag and a timeout flag. Every wait on the link is bounded by a cycle limit set on a control input. A wait that runs past it abandons the rest of the transfer. All four link inputs pass through two-flop synchronisers before the control logic uses them.

The request channel uses valid/ready. A request is taken in the cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the response has been consumed. The response channel also uses valid/ready. While `rsp_valid` is high and `rsp_ready` is low, every response field holds its value.

Top module: `slice_link_master`

## Requirements
- R1: During and after reset, `lnk_hs_o` is low, `lnk_data_o` is 00h, `req_ready` is high and `rsp_valid` is low.
- R2: To send a byte, the master puts the byte on `lnk_data_o` and raises `lnk_hs_o`. It keeps `lnk_hs_o` high until it sees `hs_i` high. It then lowers `lnk_hs_o` and waits for `hs_i` low, which completes the byte. The data lines do not change during the byte.
- R3: `req_size` encodes the byte count as value+1, so 0 means one byte and 3 means four. Sent bytes leave in order from most to least significant of the low `req_size+1` bytes of `req_data`. A received word is right-aligned in `rsp_data`, with the first byte received in the most significant used byte position. A send response has `rsp_data` = 0.
- R4: Each received byte is taken in four slices.
  - Slice 1: wait for `hs_i` high; take `ret0_i`→bit6 and `ret1_i`→bit7; raise `lnk_hs_o`.
  - Slice 2: wait for `hs_i` low; take `ret0_i`,`ret1_i`,`ret2_i`→bits 3,4,5; lower `lnk_hs_o`.
  - Slice 3: wait for `hs_i` high; take them as bits 0,1,2; raise `lnk_hs_o`.
  - Slice 4: wait for `hs_i` low; lower `lnk_hs_o`.
- R5: In slice 1, `ret2_i` must be 1. In slice 4, `ret1_i` and `ret2_i` must both be 0. Any mismatch in any byte of the transfer sets `rsp_frame_err`. The data is still assembled and returned.
- R6: `rsp_ver` is the `ret0_i` value taken in slice 4 of the last received byte. It is 0 for a send.
- R7: After slice 4, a received byte does not complete until `ret0_i`, `ret1_i`, `ret2_i` and `hs_i` are all low.
- R8: Any wait longer than `tmo_limit` cycles aborts the transfer. On an abort, `lnk_hs_o` drops low, no further bytes are moved, and the response carries `rsp_timeout` = 1.
- R9: Requests and responses follow the valid/ready rules above. The next request is accepted only after the response has been consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmo_limit | input | TMO_W | Cycle limit for every link wait |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_rx | input | 1 | 1 = receive, 0 = send |
| req_size | input | SIZE_W | Byte count minus one |
| req_data | input | WORD_W | Value to send, right-aligned |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed when high with rsp_valid |
| rsp_data | output | WORD_W | Received value, right-aligned |
| rsp_ver | output | 1 | Version flag from the last received byte |
| rsp_timeout | output | 1 | Transfer aborted by a timed-out wait |
| rsp_frame_err | output | 1 | Fixed slice bits mismatched |
| lnk_data_o | output | 8 | Outbound data lines |
| lnk_hs_o | output | 1 | Outbound handshake strobe |
| ret0_i | input | 1 | Return line 0 |
| ret1_i | input | 1 | Return line 1 |
| ret2_i | input | 1 | Return line 2 |
| hs_i | input | 1 | Peer handshake line |

## Verification
The bench goes after the scrambled slice order. It uses words whose bytes set the two top bits differently from the rest, so a design that packed slices linearly or swapped slices 1 and 3 would return a wrong word. It injects a low constant bit in slice 1 and a high bit in slice 4: a design that ignored these would report a clean frame. It holds the version line high after the last strobe drop, which shows whether a design ends the byte before the link is quiet. It stalls the peer in mid-receive and in mid-send: a design without the bound would hang, and one that did not drop the rest of the transfer would go on strobing.

// File: rtl/slice_link_pkg.sv
package slice_link_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    E_IDLE,
    E_TX_HI,
    E_TX_LO,
    E_RX1,
    E_RX2,
    E_RX3,
    E_RX4,
    E_QUIET
  } eng_st_t;

  typedef enum logic [1:0] {
    F_IDLE,
    F_ISSUE,
    F_WAIT,
    F_RSP
  } fe_st_t;

endpackage

// File: rtl/slice_link_sync.sv
module slice_link_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta   <= 1'b0;
        q_o[b] <= 1'b0;
      end else begin
        meta   <= d_i[b];
        q_o[b] <= meta;
      end
    end
  end

endmodule

// File: rtl/slice_link_timer.sv
module slice_link_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);

  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (cnt != '1) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = run && (cnt >= limit);

endmodule

// File: rtl/slice_link_engine.sv
module slice_link_engine
  import slice_link_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rx_mode,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic [3:0]        stat_s,   // {hs, ret2, ret1, ret0}, synchronised
  output logic [BYTE_W-1:0] data_o,
  output logic              hs_o,
  output logic              done,
  output logic              abort,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              ver,
  output logic              ferr
);

  eng_st_t st;
  logic    cond;
  logic    waiting;
  logic    expired;
  logic    rx_q;

  wire hs_s = stat_s[3];
  wire r0   = stat_s[0];
  wire r1   = stat_s[1];
  wire r2   = stat_s[2];

  always_comb begin
    unique case (st)
      E_TX_HI, E_RX1, E_RX3: cond = hs_s;
      E_TX_LO, E_RX2, E_RX4: cond = !hs_s;
      E_QUIET:               cond = (stat_s == 4'b0000);
      default:               cond = 1'b1;
    endcase
  end

  assign waiting = (st != E_IDLE) && !cond;

  slice_link_timer #(.TMO_W(TMO_W)) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (waiting),
    .limit   (tmo_limit),
    .expired (expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= E_IDLE;
      data_o  <= '0;
      hs_o    <= 1'b0;
      done    <= 1'b0;
      abort   <= 1'b0;
      rx_byte <= '0;
      ver     <= 1'b0;
      ferr    <= 1'b0;
      rx_q    <= 1'b0;
    end else begin
      done  <= 1'b0;
      abort <= 1'b0;
      if (expired) begin
        abort <= 1'b0 | 1'b1;
        hs_o  <= 1'b0;
        st    <= E_IDLE;
      end else begin
        unique case (st)
          E_IDLE: if (start) begin
            rx_q <= rx_mode;
            ferr <= 1'b0;
            if (rx_mode) begin
              st <= E_RX1;
            end else begin
              data_o <= tx_byte;
              hs_o   <= 1'b1;
              st     <= E_TX_HI;
            end
          end
          E_TX_HI: if (cond) begin
            hs_o <= 1'b0;
            st   <= E_TX_LO;
          end
          E_TX_LO: if (cond) begin
            done <= 1'b1;
            st   <= E_IDLE;
          end
          E_RX1: if (cond) begin
            rx_byte[6] <= r0;
            rx_byte[7] <= r1;
            if (!r2) ferr <= 1'b1;
            hs_o <= 1'b1;
            st   <= E_RX2;
          end
          E_RX2: if (cond) begin
            rx_byte[5:3] <= {r2, r1, r0};
            hs_o <= 1'b0;
            st   <= E_RX3;
          end
          E_RX3: if (cond) begin
            rx_byte[2:0] <= {r2, r1, r0};
            hs_o <= 1'b1;
            st   <= E_RX4;
          end
          E_RX4: if (cond) begin
            ver <= r0;
            if (r1 || r2) ferr <= 1'b1;
            hs_o <= 1'b0;
            st   <= E_QUIET;
          end
          E_QUIET: if (cond) begin
            done <= 1'b1;
            st   <= E_IDLE;
          end
          default: st <= E_IDLE;
        endcase
      end
    end
  end

  // R2: strobe stays high while the peer has not answered
  assert_hs_hold_tx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == E_TX_HI && !hs_s && !expired) |=> hs_o);

  // R2: outbound byte is stable throughout the handshake
  assert_tx_data_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == E_TX_HI || st == E_TX_LO) |=> $stable(data_o));

  // R7: a received byte ends only from a quiet link
  assert_quiet_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rx_q) |-> ($past(stat_s) == 4'b0000));

  // R8: abort leaves the strobe low
  assert_abort_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !hs_o);

endmodule

// File: rtl/slice_link_master.sv
module slice_link_master
  import slice_link_pkg::*;
#(
  parameter int TMO_W     = 16,
  parameter int BYTES_MAX = 4,
  parameter int WORD_W    = BYTE_W * BYTES_MAX,
  parameter int SIZE_W    = $clog2(BYTES_MAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_rx,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [WORD_W-1:0] req_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data,
  output logic              rsp_ver,
  output logic              rsp_timeout,
  output logic              rsp_frame_err,
  output logic [7:0]        lnk_data_o,
  output logic              lnk_hs_o,
  input  logic              ret0_i,
  input  logic              ret1_i,
  input  logic              ret2_i,
  input  logic              hs_i
);

  localparam int TOP_LSB = WORD_W - BYTE_W;

  fe_st_t            fst;
  logic              rx_q;
  logic [SIZE_W-1:0] left;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] acc;
  logic              ver_q, ferr_q, tmo_q;

  logic [3:0]        stat_s;
  logic              eng_done, eng_abort, eng_ver, eng_ferr;
  logic [BYTE_W-1:0] eng_rx;

  slice_link_sync #(.W(4)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({hs_i, ret2_i, ret1_i, ret0_i}),
    .q_o   (stat_s)
  );

  slice_link_engine #(.TMO_W(TMO_W)) i_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (fst == F_ISSUE),
    .rx_mode   (rx_q),
    .tx_byte   (shreg[WORD_W-1:TOP_LSB]),
    .tmo_limit (tmo_limit),
    .stat_s    (stat_s),
    .data_o    (lnk_data_o),
    .hs_o      (lnk_hs_o),
    .done      (eng_done),
    .abort     (eng_abort),
    .rx_byte   (eng_rx),
    .ver       (eng_ver),
    .ferr      (eng_ferr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fst    <= F_IDLE;
      rx_q   <= 1'b0;
      left   <= '0;
      shreg  <= '0;
      acc    <= '0;
      ver_q  <= 1'b0;
      ferr_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      unique case (fst)
        F_IDLE: if (req_valid) begin
          rx_q   <= req_rx;
          left   <= req_size;
          shreg  <= req_data << (BYTE_W * (BYTES_MAX - 1 - int'(req_size)));
          acc    <= '0;
          ver_q  <= 1'b0;
          ferr_q <= 1'b0;
          tmo_q  <= 1'b0;
          fst    <= F_ISSUE;
        end
        F_ISSUE: fst <= F_WAIT;
        F_WAIT: begin
          if (eng_abort) begin
            tmo_q <= 1'b1;
            fst   <= F_RSP;
          end else if (eng_done) begin
            if (rx_q) begin
              acc    <= {acc[TOP_LSB-1:0], eng_rx};
              ver_q  <= eng_ver;
              ferr_q <= ferr_q | eng_ferr;
            end
            shreg <= shreg << BYTE_W;
            if (left == '0) begin
              fst <= F_RSP;
            end else begin
              left <= left - 1'b1;
              fst  <= F_ISSUE;
            end
          end
        end
        F_RSP: if (rsp_ready) fst <= F_IDLE;
        default: fst <= F_IDLE;
      endcase
    end
  end

  assign req_ready     = (fst == F_IDLE);
  assign rsp_valid     = (fst == F_RSP);
  assign rsp_data      = acc;
  assign rsp_ver       = ver_q;
  assign rsp_frame_err = ferr_q;
  assign rsp_timeout   = tmo_q;

  // R9: a stalled response keeps every field
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_ver)
                                   && $stable(rsp_timeout) && $stable(rsp_frame_err)));

  // R9: no request is taken while a response is pending
  assert_no_accept_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R8: an engine step ends either normally or by abort, never both
  assert_single_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(eng_done && eng_abort));

endmodule

// File: tb/test_slice_link_master.sv
module test_slice_link_master;

  localparam int CLK_PERIOD = 10;
  localparam int DLY        = 4;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tmo_limit = 16'd200;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_rx = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_data = 32'd0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        rsp_ver, rsp_timeout, rsp_frame_err;
  logic [7:0]  lnk_data_o;
  logic        lnk_hs_o;
  logic        r0 = 1'b0, r1 = 1'b0, r2 = 1'b0, hs_in = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] c_data;
  logic        c_ver, c_tmo, c_ferr;
  logic [7:0]  got [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  slice_link_master i_slice_link_master (
    .clk           (clk),
    .rst_n         (rst_n),
    .tmo_limit     (tmo_limit),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_rx        (req_rx),
    .req_size      (req_size),
    .req_data      (req_data),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_data      (rsp_data),
    .rsp_ver       (rsp_ver),
    .rsp_timeout   (rsp_timeout),
    .rsp_frame_err (rsp_frame_err),
    .lnk_data_o    (lnk_data_o),
    .lnk_hs_o      (lnk_hs_o),
    .ret0_i        (r0),
    .ret1_i        (r1),
    .ret2_i        (r2),
    .hs_i          (hs_in)
  );

  typedef struct packed {
    logic        rx;
    logic [1:0]  sz;
    logic [31:0] val;
    logic        ver;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{rx: 1'b0, sz: 2'd0, val: 32'h000000A5, ver: 1'b0},
    '{rx: 1'b1, sz: 2'd0, val: 32'h0000003C, ver: 1'b0},
    '{rx: 1'b0, sz: 2'd1, val: 32'h00001234, ver: 1'b0},
    '{rx: 1'b1, sz: 2'd2, val: 32'h00C0FFEE, ver: 1'b1},
    '{rx: 1'b0, sz: 2'd3, val: 32'hDEADBEEF, ver: 1'b0},
    '{rx: 1'b1, sz: 2'd3, val: 32'h8001FF7E, ver: 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic wait_hs(input logic v);
    while (lnk_hs_o !== v) @(negedge clk);
  endtask

  task automatic issue(input logic rx, input logic [1:0] sz, input logic [31:0] val);
    @(negedge clk);
    req_valid = 1'b1; req_rx = rx; req_size = sz; req_data = val;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic get_rsp();
    while (!rsp_valid) @(negedge clk);
    c_data = rsp_data; c_ver = rsp_ver; c_tmo = rsp_timeout; c_ferr = rsp_frame_err;
    @(negedge clk);
  endtask

  task automatic dev_tx(input int n);
    for (int k = 0; k < n; k++) begin
      wait_hs(1'b1);
      got[k] = lnk_data_o;
      repeat (DLY) @(negedge clk);
      hs_in = 1'b1;
      wait_hs(1'b0);
      repeat (DLY) @(negedge clk);
      hs_in = 1'b0;
    end
  endtask

  task automatic dev_rx(input logic [31:0] val, input int n, input logic ver,
                        input logic bad1, input logic bad4, input int hold,
                        output int early);
    early = 0;
    for (int k = n - 1; k >= 0; k--) begin
      logic [7:0] b;
      b = val[8*k +: 8];
      repeat (DLY) @(negedge clk);
      {r0, r1, r2} = {b[6], b[7], ~bad1}; hs_in = 1'b1;
      wait_hs(1'b1);
      repeat (DLY) @(negedge clk);
      {r0, r1, r2} = {b[3], b[4], b[5]}; hs_in = 1'b0;
      wait_hs(1'b0);
      repeat (DLY) @(negedge clk);
      {r0, r1, r2} = {b[0], b[1], b[2]}; hs_in = 1'b1;
      wait_hs(1'b1);
      repeat (DLY) @(negedge clk);
      {r0, r1, r2} = {ver, bad4, 1'b0}; hs_in = 1'b0;
      wait_hs(1'b0);
      if (k == 0) begin
        for (int h = 0; h < hold; h++) begin
          @(negedge clk);
          if (rsp_valid) early++;
        end
      end
      {r0, r1, r2} = 3'b000;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int early;
    int hs_rises;
    logic [31:0] mask, held;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 hs during reset", {31'd0, lnk_hs_o}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 hs after reset", {31'd0, lnk_hs_o}, 32'd0);
    chk("R1 data lines", {24'd0, lnk_data_o}, 32'd0);
    chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);

    // table walk: R2 R3 R4 R6
    for (int i = 0; i < 6; i++) begin
      vec_t v;
      int   n;
      v = VECS[i];
      n = int'(v.sz) + 1;
      mask = (n == 4) ? 32'hFFFFFFFF : ((32'd1 << (8 * n)) - 32'd1);
      if (!v.rx) begin
        fork
          issue(1'b0, v.sz, v.val);
          dev_tx(n);
          get_rsp();
        join
        for (int k = 0; k < n; k++)
          chk("R2 R3 sent byte order", {24'd0, got[k]}, {24'd0, v.val[8*(n-1-k) +: 8]});
        chk("R3 send rsp_data zero", c_data, 32'd0);
        chk("R6 send ver zero", {31'd0, c_ver}, 32'd0);
        chk("R8 send no timeout", {31'd0, c_tmo}, 32'd0);
      end else begin
        fork
          issue(1'b1, v.sz, 32'd0);
          dev_rx(v.val, n, v.ver, 1'b0, 1'b0, 0, early);
          get_rsp();
        join
        chk("R4 R3 received word", c_data, v.val & mask);
        chk("R6 version flag", {31'd0, c_ver}, {31'd0, v.ver});
        chk("R5 clean frame", {31'd0, c_ferr}, 32'd0);
      end
    end

    // R5: slice-1 constant bit low
    fork
      issue(1'b1, 2'd1, 32'd0);
      dev_rx(32'h0000A55A, 2, 1'b0, 1'b1, 1'b0, 0, early);
      get_rsp();
    join
    chk("R5 slice1 frame err", {31'd0, c_ferr}, 32'd1);
    chk("R5 data kept on frame err", c_data, 32'h0000A55A);

    // R5: slice-4 expected-low bit high
    fork
      issue(1'b1, 2'd0, 32'd0);
      dev_rx(32'h000000C3, 1, 1'b0, 1'b0, 1'b1, 0, early);
      get_rsp();
    join
    chk("R5 slice4 frame err", {31'd0, c_ferr}, 32'd1);
    chk("R5 data kept slice4", c_data, 32'h000000C3);

    // R7: version line held high after the last strobe drop
    fork
      issue(1'b1, 2'd0, 32'd0);
      dev_rx(32'h00000071, 1, 1'b1, 1'b0, 1'b0, 20, early);
      get_rsp();
    join
    chk("R7 no response before quiet", early, 32'd0);
    chk("R7 word after quiet", c_data, 32'h00000071);
    chk("R6 version after hold", {31'd0, c_ver}, 32'd1);

    // R9: back-pressure on the response
    rsp_ready = 1'b0;
    fork
      issue(1'b1, 2'd0, 32'd0);
      dev_rx(32'h0000005A, 1, 1'b0, 1'b0, 1'b0, 0, early);
    join
    while (!rsp_valid) @(negedge clk);
    held = rsp_data;
    repeat (5) @(negedge clk);
    chk("R9 rsp_valid held", {31'd0, rsp_valid}, 32'd1);
    chk("R9 rsp_data held", rsp_data, held);
    chk("R9 req_ready low while pending", {31'd0, req_ready}, 32'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R9 rsp consumed", {31'd0, rsp_valid}, 32'd0);
    chk("R9 ready again", {31'd0, req_ready}, 32'd1);

    // R8: receive with a silent peer
    tmo_limit = 16'd30;
    fork
      issue(1'b1, 2'd3, 32'd0);
      get_rsp();
    join
    chk("R8 rx timeout flag", {31'd0, c_tmo}, 32'd1);
    chk("R8 rx no data", c_data, 32'd0);
    chk("R8 rx strobe low", {31'd0, lnk_hs_o}, 32'd0);

    // R8: send where the peer never releases its handshake
    fork
      issue(1'b0, 2'd1, 32'h0000ABCD);
      begin
        wait_hs(1'b1);
        got[0] = lnk_data_o;
        repeat (DLY) @(negedge clk);
        hs_in = 1'b1;
      end
      get_rsp();
    join
    chk("R8 tx timeout flag", {31'd0, c_tmo}, 32'd1);
    chk("R8 first byte sent", {24'd0, got[0]}, 32'h000000AB);
    hs_rises = 0;
    for (int w = 0; w < 40; w++) begin
      @(negedge clk);
      if (lnk_hs_o) hs_rises++;
    end
    chk("R8 rest of transfer dropped", hs_rises, 32'd0);
    hs_in = 1'b0;
    repeat (10) @(negedge clk);

    finished = 1;
    summary();
    $finish;
  end

endmodule